// File: doc/BRIEF.md
# Bidirectional GPIO Register Port

This block provides sixteen general-purpose pins whose direction can be changed while the system runs. All control sits in one 32-bit register behind an AXI4-Lite slave port. The upper half of the register selects the direction of each pin and the lower half carries the pin values. On the pad side the block drives an output value and an active-high output enable for every pin, and it receives the raw pad level.

A read of the value half always returns what is really on each pin. For an input pin this is the pad level after a two-flop synchroniser. For an output pin it is the level being driven. Because of this, several processors can share the port: each one reads the register, changes only its own bits and writes the whole word back, and it never wipes out output levels owned by another processor.

The register responds at one word-aligned offset. Any other offset reads as zero, ignores writes and still returns an OKAY response.

Top module: `gpio_bidir_port`

## Requirements
- R1: After a synchronous active-low reset every pin is an input (all direction bits 1), every stored output bit is 0, `pad_oe` is all zero and no write or read response is pending.
- R2: Pin N is an output exactly when direction bit N+16 of the register is 0. In that state `pad_oe[N]` is 1 and `pad_out[N]` carries the stored output bit N. A new value appears on the pads in the cycle after the write handshake, and the pads do not change in any cycle without a write to the register.
- R3: Read data bits 31:16 at the register offset return the direction register, with bit N+16 belonging to pin N.
- R4: Read data bits 15:0 at the register offset return the live pin state. Bit N is the driven output bit when pin N is an output, and the pad level delayed by two clock edges of synchronisation when pin N is an input.
- R5: A write to the output bit of an input pin is stored. That value drives the pad as soon as the pin is switched to output, even if the output byte lanes are not written again.
- R6: Write strobes select byte lanes. Lane 0 covers output bits 7:0, lane 1 covers output bits 15:8, lane 2 covers direction bits for pins 7:0 and lane 3 covers direction bits for pins 15:8. Lanes whose strobe is clear keep their old contents.
- R7: The register decodes at byte offset 0x34 (address bits 1:0 are ignored). A read at any other word returns 0, a write there changes nothing, and every response code is OKAY (2'b00).
- R8: A write is accepted in the cycle where `s_awvalid` and `s_wvalid` are both high and no write response is pending. `s_awready` and `s_wready` are high together in exactly that cycle. `s_bvalid` rises in the next cycle and stays high until `s_bready`.
- R9: `s_arready` is high whenever no read response is pending. After a read is accepted, `s_rvalid` rises in the next cycle and `s_rdata` stays unchanged until `s_rready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| pad_in | input | 16 | Raw pad levels, asynchronous |
| pad_out | output | 16 | Output values to the pads |
| pad_oe | output | 16 | Output enables to the pads, 1 drives the pin |

## Verification
A wrong direction bit is visible at `pad_oe` in the cycle after the write that set it. A wrong stored output bit is visible at `pad_out` at once, including for a pin currently set as input, and the bench compares both buses on every clock. A fault in the synchroniser or in the live-value select only appears through reads, so the bench issues reads while pads and directions change. The read data is then checked two edges after each pad change against a model that delays the pad level independently. A handshake fault, such as a lost response, a second write accepted while a response is pending, or read data changing while it is held, shows up in the very cycle it happens, because the ready and valid outputs are compared on every clock.

// File: rtl/gpio_port_pkg.sv
// Package: shared widths, response codes and the internal write-request
// type for the bidirectional GPIO register port.
// Assumes a 32-bit AXI4-Lite data path with four byte lanes.
package gpio_port_pkg;

    localparam int unsigned AXIL_DATA_W = 32;
    localparam int unsigned AXIL_STRB_W = AXIL_DATA_W / 8;
    localparam int unsigned HALF_W      = AXIL_DATA_W / 2;

    typedef logic [1:0] axi_resp_t;
    localparam axi_resp_t RESP_OKAY = 2'b00;

    // One accepted, decoded register write
    typedef struct packed {
        logic                   en;
        logic [AXIL_DATA_W-1:0] data;
        logic [AXIL_STRB_W-1:0] strb;
    } reg_wr_t;

endpackage

// File: rtl/gpio_axil_frontend.sv
// Module: gpio_axil_frontend
// AXI4-Lite slave for a single register word. A write is accepted when
// address and data are both valid and no response is pending. A read is
// accepted whenever no read data is pending, and the word is captured in that
// cycle. Unmatched words read as zero and produce no register write.
// Assumes: a synchronous active-low reset; responses are always OKAY.
module gpio_axil_frontend
    import gpio_port_pkg::*;
#(
    parameter int unsigned           ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]     REG_OFFSET = 'h34
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      awaddr_i,
    input  logic                   awvalid_i,
    output logic                   awready_o,
    input  logic [AXIL_DATA_W-1:0] wdata_i,
    input  logic [AXIL_STRB_W-1:0] wstrb_i,
    input  logic                   wvalid_i,
    output logic                   wready_o,
    output logic                   bvalid_o,
    input  logic                   bready_i,
    input  logic [ADDR_W-1:0]      araddr_i,
    input  logic                   arvalid_i,
    output logic                   arready_o,
    output logic [AXIL_DATA_W-1:0] rdata_o,
    output logic                   rvalid_o,
    input  logic                   rready_i,
    input  logic [AXIL_DATA_W-1:0] rd_word_i,
    output reg_wr_t                wr_o
);

    localparam int unsigned WORD_LSB = $clog2(AXIL_STRB_W);

    logic                   bvalid_q;
    logic                   rvalid_q;
    logic [AXIL_DATA_W-1:0] rdata_q;
    logic                   wr_fire;
    logic                   rd_fire;
    logic                   aw_hit;
    logic                   ar_hit;
    logic                   unused_addr_lsbs;

    // Word decode: address bits below the word boundary are ignored
    assign aw_hit = (awaddr_i[ADDR_W-1:WORD_LSB] == REG_OFFSET[ADDR_W-1:WORD_LSB]);
    assign ar_hit = (araddr_i[ADDR_W-1:WORD_LSB] == REG_OFFSET[ADDR_W-1:WORD_LSB]);
    assign unused_addr_lsbs = ^{awaddr_i[WORD_LSB-1:0], araddr_i[WORD_LSB-1:0]};

    // Handshake qualifiers
    assign wr_fire   = awvalid_i & wvalid_i & ~bvalid_q;
    assign rd_fire   = arvalid_i & ~rvalid_q;
    assign awready_o = wr_fire;
    assign wready_o  = wr_fire;
    assign arready_o = ~rvalid_q;
    assign bvalid_o  = bvalid_q;
    assign rvalid_o  = rvalid_q;
    assign rdata_o   = rdata_q;

    // Register-side write request
    always_comb begin
        wr_o.en   = wr_fire & aw_hit;
        wr_o.data = wdata_i;
        wr_o.strb = wstrb_i;
    end

    // Write response: raised after an accepted write, held until taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
        end else if (wr_fire) begin
            bvalid_q <= 1'b1;
        end else if (bready_i) begin
            bvalid_q <= 1'b0;
        end
    end

    // Read channel: capture the word on acceptance, hold until taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= ar_hit ? rd_word_i : '0;
        end else if (rready_i) begin
            rvalid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/gpio_pin_regs.sv
// Module: gpio_pin_regs
// Per-pin direction and output-data flops. The direction bit of pin N sits at
// word bit HALF_W+N and its output bit at word bit N; each bit follows the
// strobe of its own byte lane. Reset makes every pin an input with output 0.
// Assumes: NUM_PINS <= HALF_W.
module gpio_pin_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  reg_wr_t             wr_i,
    output logic [NUM_PINS-1:0] dir_in_o,
    output logic [NUM_PINS-1:0] out_val_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int unsigned OUT_BIT  = p;
        localparam int unsigned DIR_BIT  = HALF_W + p;
        localparam int unsigned OUT_LANE = OUT_BIT / 8;
        localparam int unsigned DIR_LANE = DIR_BIT / 8;

        logic dir_q;
        logic val_q;

        // Pin state: lane-qualified update of direction and output bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q <= 1'b1;
                val_q <= 1'b0;
            end else if (wr_i.en) begin
                if (wr_i.strb[DIR_LANE]) dir_q <= wr_i.data[DIR_BIT];
                if (wr_i.strb[OUT_LANE]) val_q <= wr_i.data[OUT_BIT];
            end
        end

        assign dir_in_o[p]  = dir_q;
        assign out_val_o[p] = val_q;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Multi-stage synchroniser for asynchronous pad levels. The output is the
// input delayed by STAGES clock edges. Reset clears all stages.
// Assumes: STAGES >= 2.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift chain from the pads toward the read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bidir_port.sv
// Module: gpio_bidir_port (top)
// Bidirectional GPIO port behind one AXI4-Lite register. The upper half of
// the word selects direction (1 = input) and the lower half holds the pin
// values. Reads return the live level of every pin: the synchronised pad for
// inputs, the driven value for outputs.
// Assumes: the pad buffers are outside; pad_oe = 1 drives the pin.
module gpio_bidir_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned       NUM_PINS    = 16,
    parameter int unsigned       ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET  = 'h34,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      s_awaddr,
    input  logic                   s_awvalid,
    output logic                   s_awready,
    input  logic [AXIL_DATA_W-1:0] s_wdata,
    input  logic [AXIL_STRB_W-1:0] s_wstrb,
    input  logic                   s_wvalid,
    output logic                   s_wready,
    output logic [1:0]             s_bresp,
    output logic                   s_bvalid,
    input  logic                   s_bready,
    input  logic [ADDR_W-1:0]      s_araddr,
    input  logic                   s_arvalid,
    output logic                   s_arready,
    output logic [AXIL_DATA_W-1:0] s_rdata,
    output logic [1:0]             s_rresp,
    output logic                   s_rvalid,
    input  logic                   s_rready,
    input  logic [NUM_PINS-1:0]    pad_in,
    output logic [NUM_PINS-1:0]    pad_out,
    output logic [NUM_PINS-1:0]    pad_oe
);

    reg_wr_t                wr_req;
    logic [NUM_PINS-1:0]    dir_in;
    logic [NUM_PINS-1:0]    out_val;
    logic [NUM_PINS-1:0]    pad_sync;
    logic [NUM_PINS-1:0]    live_val;
    logic [AXIL_DATA_W-1:0] rd_word;

    gpio_axil_frontend #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .awaddr_i  (s_awaddr),
        .awvalid_i (s_awvalid),
        .awready_o (s_awready),
        .wdata_i   (s_wdata),
        .wstrb_i   (s_wstrb),
        .wvalid_i  (s_wvalid),
        .wready_o  (s_wready),
        .bvalid_o  (s_bvalid),
        .bready_i  (s_bready),
        .araddr_i  (s_araddr),
        .arvalid_i (s_arvalid),
        .arready_o (s_arready),
        .rdata_o   (s_rdata),
        .rvalid_o  (s_rvalid),
        .rready_i  (s_rready),
        .rd_word_i (rd_word),
        .wr_o      (wr_req)
    );

    gpio_pin_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_req),
        .dir_in_o  (dir_in),
        .out_val_o (out_val)
    );

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    // Live pin level: synchronised pad for inputs, driven bit for outputs
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            live_val[p] = dir_in[p] ? pad_sync[p] : out_val[p];
        end
    end

    // Register image: direction in the upper half, live values in the lower
    always_comb begin
        rd_word                     = '0;
        rd_word[HALF_W +: NUM_PINS] = dir_in;
        rd_word[0 +: NUM_PINS]      = live_val;
    end

    assign pad_oe  = ~dir_in;
    assign pad_out = out_val;
    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

endmodule

// File: rtl/gpio_port_checker.sv
// Module: gpio_port_checker
// Port-level protocol and behaviour properties for gpio_bidir_port, attached
// through the bind below. Observes ports only.
module gpio_port_checker #(
    parameter int unsigned       NUM_PINS   = 16,
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h34
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   s_awaddr,
    input logic                s_awvalid,
    input logic                s_awready,
    input logic                s_bvalid,
    input logic                s_bready,
    input logic [1:0]          s_bresp,
    input logic [ADDR_W-1:0]   s_araddr,
    input logic                s_arvalid,
    input logic                s_arready,
    input logic [31:0]         s_rdata,
    input logic [1:0]          s_rresp,
    input logic                s_rvalid,
    input logic                s_rready,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);

    logic ar_hit;
    logic unused_aw;
    assign ar_hit    = (s_araddr[ADDR_W-1:2] == REG_OFFSET[ADDR_W-1:2]);
    assign unused_aw = ^s_awaddr;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0) && !s_bvalid && !s_rvalid);

    p_pads_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_awvalid && s_awready) |=> $stable(pad_oe) && $stable(pad_out));

    p_dir_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && ar_hit) |=> (s_rdata[16 +: NUM_PINS] == ~$past(pad_oe)));

    p_okay_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00) && (s_rresp == 2'b00));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && !ar_hit) |=> (s_rdata == '0));

    p_bresp_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready);

    p_rdata_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> s_rvalid && $stable(s_rdata));

    p_ar_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);

endmodule

bind gpio_bidir_port gpio_port_checker #(
    .NUM_PINS   (NUM_PINS),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awaddr  (s_awaddr),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .s_araddr  (s_araddr),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_bidir_port_tb_top.sv
// Bench: a behavioural reference model updated on every rising edge and
// compared with all outputs at every falling edge, plus directed checks.
module gpio_bidir_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [7:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [15:0] pad_in = 16'h5A3C;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;

    always #5 clk = ~clk;

    gpio_bidir_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state
    logic [15:0] m_dir, m_out, m_s1, m_s2;
    logic        m_bvalid, m_rvalid;
    logic [31:0] m_rdata;

    // Model update at each rising edge, from the requirements
    always @(posedge clk) begin
        logic [31:0] word;
        logic [15:0] live;
        bit          wr_ok, rd_ok;
        if (!rst_n) begin
            m_dir = 16'hFFFF; m_out = '0; m_s1 = '0; m_s2 = '0;
            m_bvalid = 0; m_rvalid = 0; m_rdata = '0;
        end else begin
            live  = (m_dir & m_s2) | (~m_dir & m_out);
            wr_ok = s_awvalid && s_wvalid && !m_bvalid;
            rd_ok = s_arvalid && !m_rvalid;
            if (rd_ok) begin
                m_rvalid = 1;
                m_rdata  = (s_araddr[7:2] == 6'h0D) ? {m_dir, live} : 32'h0;
            end else if (m_rvalid && s_rready) begin
                m_rvalid = 0;
            end
            if (wr_ok) begin
                m_bvalid = 1;
                if (s_awaddr[7:2] == 6'h0D) begin
                    word = {m_dir, m_out};
                    for (int b = 0; b < 4; b++)
                        if (s_wstrb[b]) word[b*8 +: 8] = s_wdata[b*8 +: 8];
                    m_dir = word[31:16];
                    m_out = word[15:0];
                end
            end else if (m_bvalid && s_bready) begin
                m_bvalid = 0;
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 pad_oe", {16'h0, pad_oe}, {16'h0, ~m_dir});
            chk("R2/R5 pad_out", {16'h0, pad_out}, {16'h0, m_out});
            chk("R8 awready", {31'h0, s_awready}, {31'h0, s_awvalid && s_wvalid && !m_bvalid});
            chk("R8 wready", {31'h0, s_wready}, {31'h0, s_awvalid && s_wvalid && !m_bvalid});
            chk("R8 bvalid", {31'h0, s_bvalid}, {31'h0, m_bvalid});
            chk("R9 arready", {31'h0, s_arready}, {31'h0, !m_rvalid});
            chk("R9 rvalid", {31'h0, s_rvalid}, {31'h0, m_rvalid});
            if (m_rvalid) begin
                chk("R3 rdata dir", {16'h0, s_rdata[31:16]}, {16'h0, m_rdata[31:16]});
                chk("R4 rdata live", {16'h0, s_rdata[15:0]}, {16'h0, m_rdata[15:0]});
                chk("R7 rresp", {30'h0, s_rresp}, 32'h0);
            end
            if (m_bvalid) chk("R7 bresp", {30'h0, s_bresp}, 32'h0);
        end
    end

    task automatic axi_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] st, input int bwait);
        bit hs;
        s_awaddr = a; s_wdata = d; s_wstrb = st;
        s_awvalid = 1; s_wvalid = 1; s_bready = 0;
        do begin @(negedge clk); hs = s_awready; @(posedge clk); #2; end while (!hs);
        s_awvalid = 0; s_wvalid = 0;
        repeat (bwait) begin @(posedge clk); #2; end
        s_bready = 1;
        do begin @(negedge clk); hs = s_bvalid; @(posedge clk); #2; end while (!hs);
        s_bready = 0;
    endtask

    task automatic axi_read(input logic [7:0] a, input int rwait, output logic [31:0] d);
        bit hs;
        logic [31:0] first;
        s_araddr = a; s_arvalid = 1; s_rready = 0;
        do begin @(negedge clk); hs = s_arready; @(posedge clk); #2; end while (!hs);
        s_arvalid = 0;
        @(negedge clk); first = s_rdata;
        repeat (rwait) begin
            @(posedge clk); #2; @(negedge clk);
            chk("R9 rdata held", s_rdata, first);
        end
        @(posedge clk); #2;
        s_rready = 1;
        do begin @(negedge clk); hs = s_rvalid; d = s_rdata; @(posedge clk); #2; end while (!hs);
        s_rready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #2 cmp_en = 1;
        @(negedge clk);
        chk("R1 pad_oe after reset", {16'h0, pad_oe}, 32'h0);
        chk("R1 pad_out after reset", {16'h0, pad_out}, 32'h0);
        rst_n = 1;
        repeat (3) begin @(posedge clk); #2; end

        axi_read(8'h34, 0, rd);
        chk("R1/R4 reset read", rd, 32'hFFFF_5A3C);

        axi_write(8'h34, 32'h00FF_1234, 4'hF, 0);
        @(negedge clk);
        chk("R2 oe after write", {16'h0, pad_oe}, 32'h0000_FF00);
        chk("R2 out after write", {16'h0, pad_out}, 32'h0000_1234);
        @(posedge clk); #2;
        axi_read(8'h34, 0, rd);
        chk("R3/R4 mixed read", rd, 32'h00FF_123C);

        axi_write(8'h34, 32'hFFFF_ABCD, 4'b0010, 2);
        @(negedge clk);
        chk("R6 lane1 only out", {16'h0, pad_out}, 32'h0000_AB34);
        chk("R6 lane1 only oe", {16'h0, pad_oe}, 32'h0000_FF00);
        @(posedge clk); #2;

        axi_write(8'h30, 32'h0000_0000, 4'hF, 0);
        axi_write(8'h38, 32'h0000_0000, 4'hF, 1);
        @(negedge clk);
        chk("R7 stray write oe", {16'h0, pad_oe}, 32'h0000_FF00);
        chk("R7 stray write out", {16'h0, pad_out}, 32'h0000_AB34);
        @(posedge clk); #2;
        axi_read(8'h30, 0, rd);
        chk("R7 stray read", rd, 32'h0);
        axi_read(8'h37, 0, rd);
        chk("R7 low addr bits ignored", rd, 32'h00FF_AB3C);

        axi_write(8'h34, 32'hFFFF_BEEF, 4'hF, 0);
        @(negedge clk);
        chk("R5 input pin oe", {16'h0, pad_oe}, 32'h0);
        @(posedge clk); #2;
        pad_in = 16'h0F0F;
        repeat (3) begin @(posedge clk); #2; end
        axi_read(8'h34, 4, rd);
        chk("R4/R9 input read", rd, 32'hFFFF_0F0F);
        axi_write(8'h34, 32'h0000_0000, 4'b1100, 0);
        @(negedge clk);
        chk("R5 kept value drives", {16'h0, pad_out}, 32'h0000_BEEF);
        chk("R5 all outputs", {16'h0, pad_oe}, 32'h0000_FFFF);
        @(posedge clk); #2;

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            s_awvalid = r[0]; s_wvalid = r[1]; s_bready = r[2];
            s_arvalid = r[3]; s_rready = r[4];
            s_awaddr = (r[6:5] == 0) ? 8'h34 : (r[6:5] == 1) ? 8'h30 :
                       (r[6:5] == 2) ? 8'h34 : 8'h00;
            s_araddr = r[7] ? 8'h34 : 8'h38;
            s_wstrb = r[11:8];
            s_wdata = $urandom;
            if (r[12]) pad_in = r[31:16];
            @(posedge clk); #2;
        end
        s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
        s_bready = 1; s_rready = 1;
        repeat (3) begin @(posedge clk); #2; end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule